// File: doc/BRIEF.md
# Write-Busy Status Read Logic

This block sits on the read-data path of a byte-wide nonvolatile memory model. It reports to the host whether an internal programming cycle is still running. A busy flag from the programming timer selects what a read returns. While it is low, a read returns the array data unchanged. While it is high, a read returns a status byte.

The status byte carries two independent end-of-write indicators. The poll bit holds the inverse of the same bit of the last byte written. The toggle bit changes value between one read and the next. The other bits repeat the last written byte. A write that protection suppresses still keeps the timer busy. Reads during that window are therefore status polls, with no extra logic in this block. Polling may begin on the first read after a write is launched.

A read access exists while chip enable is low, output enable is low and write enable is high; one read is a run of consecutive clock cycles with access present. A three-state controller tracks the access: `RS_IDLE` (no access), `RS_STATUS` (access while busy) and `RS_ARRAY` (access while not busy). Its transitions are:
- start-status: `RS_IDLE` to `RS_STATUS`
- start-array: `RS_IDLE` to `RS_ARRAY`
- end-status: `RS_STATUS` to `RS_IDLE`, the only transition that advances the toggle bit
- busy-drop: `RS_STATUS` to `RS_ARRAY`
- busy-rise: `RS_ARRAY` to `RS_STATUS`
- end-array: `RS_ARRAY` to `RS_IDLE`

Outputs are registered. The bus value in a cycle reflects the inputs sampled at the clock edge that opens it.

Top module: `wr_busy_poll_rd`

## Requirements
- R1: `dq_oe_o` is 1 in the cycle after an edge that sampled `ce_n_i`=0, `oe_n_i`=0, `we_n_i`=1, and 0 after any other sampled combination.
- R2: Whenever `dq_oe_o` is 0, `dq_o` is all zeros.
- R3: For a read sampled with `busy_i`=1, bit 7 (`POLL_BIT`) of `dq_o` is the inverse of bit 7 of `last_wr_i`.
- R4: For reads sampled with `busy_i`=1, bit 6 (`TOGGLE_BIT`) of `dq_o` is the toggle state. That state inverts at the first edge with no access after a read that was in `RS_STATUS`, so successive busy reads alternate 0,1,0,1.
- R5: For a read sampled with `busy_i`=1, all bits other than 7 and 6 equal the same bits of `last_wr_i`, whatever `arr_rd_i` holds.
- R6: For a read sampled with `busy_i`=0, `dq_o` equals `arr_rd_i` on all eight bits.
- R7: The toggle state does not change while no status read is open. Idle periods, array reads and write-enabled cycles leave it as it was, and the next busy read shows the value that the previous busy read sequence left behind.
- R8: Polling is valid from the first busy read. The first busy read after reset returns toggle value `TOG_INIT` (0), with no extra read needed to arm it.
- R9: If `busy_i` falls during a read, the next cycle returns array data. That read does not advance the toggle state.
- R10: While `rst_n` is low, `dq_o` is 0 and `dq_oe_o` is 0, and the toggle state is loaded with `TOG_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Programming cycle in progress, from the timer |
| last_wr_i | input | DATA_W | Last byte presented for writing (stored or suppressed) |
| arr_rd_i | input | DATA_W | Array read data at the current address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| dq_o | output | DATA_W | Byte for the data bus |
| dq_oe_o | output | 1 | Drive enable for the pad drivers |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, the poll indicator on bit 7, the toggle indicator on bit 6 and a toggle reset value of 0. These defaults let one fixed last-written byte pattern separate the three kinds of status bits. They also make the toggle value of the first busy read after reset known in advance, so R8 can be checked directly. The sequences reach every controller transition, including busy falling and rising inside one read. They also reach write-enabled cycles during busy, which must leave the toggle state untouched.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_STATUS = 2'd1,
        RS_ARRAY  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/wbp_fsm.sv
module wbp_fsm
    import wbp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_access,
    input  logic      busy,
    output rd_state_e state_q,
    output logic      status_done
);

    rd_state_e state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (rd_access) begin
                    state_d = busy ? RS_STATUS : RS_ARRAY;   // start-status / start-array
                end
            end
            RS_STATUS: begin
                if (!rd_access) begin
                    state_d = RS_IDLE;                       // end-status
                end else if (!busy) begin
                    state_d = RS_ARRAY;                      // busy-drop
                end
            end
            RS_ARRAY: begin
                if (!rd_access) begin
                    state_d = RS_IDLE;                       // end-array
                end else if (busy) begin
                    state_d = RS_STATUS;                     // busy-rise
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // a status read closes: the toggle step request
    assign status_done = (state_q == RS_STATUS) && !rd_access;

endmodule

// File: rtl/wbp_toggle.sv
module wbp_toggle #(
    parameter logic TOG_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic tog_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= TOG_INIT;
        end else if (step) begin
            tog_q <= ~tog_q;
        end
    end

endmodule

// File: rtl/wbp_out_stage.sv
module wbp_out_stage #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned POLL_BIT   = DATA_W - 1,
    parameter int unsigned TOGGLE_BIT = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_access,
    input  logic              busy,
    input  logic              tog,
    input  logic [DATA_W-1:0] last_wr,
    input  logic [DATA_W-1:0] arr_rd,
    output logic [DATA_W-1:0] dq_q,
    output logic              dq_oe_q
);

    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] next_word;

    // assemble the status byte bit by bit
    for (genvar b = 0; b < DATA_W; b++) begin : g_status
        if (b == POLL_BIT) begin : g_poll
            assign status_word[b] = ~last_wr[b];
        end else if (b == TOGGLE_BIT) begin : g_tog
            assign status_word[b] = tog;
        end else begin : g_echo
            assign status_word[b] = last_wr[b];
        end
    end

    always_comb begin
        if (!rd_access) begin
            next_word = '0;
        end else if (busy) begin
            next_word = status_word;
        end else begin
            next_word = arr_rd;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q    <= '0;
            dq_oe_q <= 1'b0;
        end else begin
            dq_q    <= next_word;
            dq_oe_q <= rd_access;
        end
    end

endmodule

// File: rtl/wr_busy_poll_rd.sv
module wr_busy_poll_rd
    import wbp_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned POLL_BIT   = DATA_W - 1,
    parameter int unsigned TOGGLE_BIT = DATA_W - 2,
    parameter logic        TOG_INIT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] last_wr_i,
    input  logic [DATA_W-1:0] arr_rd_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    logic      rd_access;
    logic      step_tog;
    logic      tog_q;
    logic      status_rd;
    rd_state_e state_q;

    assign rd_access = !ce_n_i && !oe_n_i && we_n_i;
    assign status_rd = (state_q == RS_STATUS);

    wbp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_access   (rd_access),
        .busy        (busy_i),
        .state_q     (state_q),
        .status_done (step_tog)
    );

    wbp_toggle #(
        .TOG_INIT (TOG_INIT)
    ) u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_tog),
        .tog_q (tog_q)
    );

    wbp_out_stage #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_access (rd_access),
        .busy      (busy_i),
        .tog       (tog_q),
        .last_wr   (last_wr_i),
        .arr_rd    (arr_rd_i),
        .dq_q      (dq_o),
        .dq_oe_q   (dq_oe_o)
    );

endmodule

// File: rtl/wr_busy_poll_rd_chk.sv
module wr_busy_poll_rd_chk #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned POLL_BIT   = DATA_W - 1,
    parameter int unsigned TOGGLE_BIT = DATA_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_i,
    input logic [DATA_W-1:0] last_wr_i,
    input logic [DATA_W-1:0] arr_rd_i,
    input logic              ce_n_i,
    input logic              oe_n_i,
    input logic              we_n_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              tog,
    input logic              status_rd
);

    logic acc;
    assign acc = !ce_n_i && !oe_n_i && we_n_i;

    p_oe_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> dq_oe_o);

    p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !dq_oe_o);

    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o |-> (dq_o == '0));

    p_poll_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy_i) |=> (dq_o[POLL_BIT] == ~$past(last_wr_i[POLL_BIT])));

    p_toggle_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy_i) |=> (dq_o[TOGGLE_BIT] == $past(tog)));

    p_array_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !busy_i) |=> (dq_o == $past(arr_rd_i)));

    p_toggle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> $stable(tog));

endmodule

bind wr_busy_poll_rd wr_busy_poll_rd_chk #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_i    (busy_i),
    .last_wr_i (last_wr_i),
    .arr_rd_i  (arr_rd_i),
    .ce_n_i    (ce_n_i),
    .oe_n_i    (oe_n_i),
    .we_n_i    (we_n_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .tog       (tog_q),
    .status_rd (status_rd)
);

// File: tb/wr_busy_poll_rd_tb.sv
module wr_busy_poll_rd_tb;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy_i = 1'b0;
    logic [DW-1:0] last_wr_i = '0;
    logic [DW-1:0] arr_rd_i = '0;
    logic          ce_n_i = 1'b1;
    logic          oe_n_i = 1'b1;
    logic          we_n_i = 1'b1;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;

    always #2.5 clk = ~clk;

    wr_busy_poll_rd u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy_i),
        .last_wr_i (last_wr_i),
        .arr_rd_i  (arr_rd_i),
        .ce_n_i    (ce_n_i),
        .oe_n_i    (oe_n_i),
        .we_n_i    (we_n_i),
        .dq_o      (dq_o),
        .dq_oe_o   (dq_oe_o)
    );

    typedef struct {
        logic          oe;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic mtog = 1'b0;
    logic prev_status = 1'b0;
    logic running = 1'b0;

    // driver: one cycle of stimulus plus its expected result
    task automatic step(input logic ce, input logic oe, input logic we, input logic bz,
                        input logic [DW-1:0] lw, input logic [DW-1:0] ar, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        ce_n_i = ce; oe_n_i = oe; we_n_i = we; busy_i = bz;
        last_wr_i = lw; arr_rd_i = ar;
        acc = !ce && !oe && we;
        e.oe = acc;
        e.tag = tag;
        if (!acc) e.d = '0;
        else if (bz) e.d = {~lw[7], mtog, lw[5:0]};
        else e.d = ar;
        q.push_back(e);
        if (prev_status && !acc) mtog = ~mtog;
        prev_status = acc && bz;
    endtask

    task automatic rd(input int n, input logic bz, input logic [DW-1:0] lw,
                      input logic [DW-1:0] ar, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, bz, lw, ar + 8'(i), tag);
        step(1'b1, 1'b1, 1'b1, bz, lw, ar, "R2");
    endtask

    // monitor: compare after each capturing edge
    always @(posedge clk) begin
        #1;
        if (running && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (dq_o !== e.d || dq_oe_o !== e.oe) begin
                n_bad++;
                $display("FAIL %s: dq=%h oe=%b expected dq=%h oe=%b",
                         e.tag, dq_o, dq_oe_o, e.d, e.oe);
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R10: outputs quiet during reset even with a read requested
        ce_n_i = 1'b0; oe_n_i = 1'b0; busy_i = 1'b1; arr_rd_i = 8'hFF;
        repeat (4) @(negedge clk);
        n_chk++;
        if (dq_o !== '0 || dq_oe_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: dq=%h oe=%b expected dq=00 oe=0", dq_o, dq_oe_o);
        end
        ce_n_i = 1'b1; oe_n_i = 1'b1; busy_i = 1'b0;
        rst_n = 1'b1;
        running = 1'b1;

        step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h99, "R2");
        // R6: idle array reads
        rd(2, 1'b0, 8'h00, 8'h3C, "R6");
        rd(1, 1'b0, 8'h11, 8'hC3, "R6");
        // R1: no drive with write enable low or output enable high
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h55, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h55, "R1");
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h55, "R1");
        // R8: first busy read shows toggle 0 at once
        rd(1, 1'b1, 8'hA5, 8'h00, "R8 R3");
        // R4 R5: successive busy reads alternate, array data ignored
        rd(2, 1'b1, 8'hA5, 8'hF0, "R4 R5");
        rd(3, 1'b1, 8'hA5, 8'h0F, "R4 R5");
        rd(1, 1'b1, 8'hA5, 8'h77, "R4 R3");
        // R7: write-enabled and idle cycles during busy leave toggle alone
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h00, "R7 R1");
        step(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h00, "R7 R1");
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h00, "R7");
        rd(1, 1'b1, 8'hA5, 8'h00, "R7 R4");
        // R9: busy falls inside a read
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h12, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h34, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h56, "R9");
        step(1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h00, "R9");
        // R7: array reads while idle keep the toggle value
        rd(2, 1'b0, 8'h5A, 8'hE1, "R7 R6");
        rd(1, 1'b0, 8'h5A, 8'h1E, "R7 R6");
        rd(1, 1'b1, 8'h5A, 8'h00, "R7 R9 R3");
        // busy rises inside an array read, then more polling
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h24, 8'h81, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h24, 8'h82, "R3 R5");
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h24, 8'h00, "R2");
        rd(1, 1'b1, 8'hDB, 8'h00, "R4 R3 R5");
        rd(1, 1'b1, 8'hDB, 8'h00, "R4");
        rd(2, 1'b0, 8'hDB, 8'hDB, "R6");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule